// File: doc/BRIEF.md
# Dual-Rail Register Stage with Full-Word Completion

This block is one stage of a delay-insensitive pipeline. Each of its N bits travels on two rails. Every rail is held by a two-input hysteresis gate. The gate's other input is the request line `ki`, which comes from the stage downstream. The stage passes a DATA wavefront only when `ki` asks for data, and it passes a NULL wavefront only when `ki` asks for null. Between those events it holds what it has.

Each bit makes its own acknowledge by NORing its two output rails. A tree of hysteresis gates, each with at most four inputs, merges those acknowledges into one full-word acknowledge, `ko`. The stage upstream uses `ko` as its request line. The whole exchange is a four-phase handshake, and it takes the place of a valid/ready pair:
- `ki` high acts as "ready for DATA".
- `ko` falling acts as "DATA accepted".
- The upstream stage must then send NULL before the next DATA.

Back-pressure is simple. A stage whose `ki` stays low never takes new DATA. A stage whose `ki` stays high never lets go of the DATA it holds.

The hysteresis gates are modelled as state elements clocked by `clk`. Each tree level therefore adds one cycle to the path from the rails to `ko`. After reset the stage holds either NULL or a DATA word chosen by parameters.

Top module: `dr_reg_stage`

## Requirements
- R1: Bit i is coded on (`*_r1[i]`, `*_r0[i]`):
  - 01 is DATA1.
  - 10 is DATA0.
  - 00 is NULL.
  - 11 is illegal.
  
  A passed wavefront shows at the outputs with the same code it had at the inputs.
- R2: A bit's output changes from NULL to DATA only in the cycle after a clock edge at which `ki` was 1. When `ki` is 0, a DATA input leaves a NULL output unchanged.
- R3: A bit's output changes from DATA to NULL only in the cycle after a clock edge at which `ki` was 0. When `ki` is 1, a NULL input leaves a DATA output unchanged.
- R4: `ko` is 0 when every bit holds DATA and 1 when every bit holds NULL. It is the merge of the per-bit NOR acknowledges.
- R5: `ko` falls only when every output bit holds DATA. It stays 1 for as long as any bit is still NULL.
- R6: `ko` rises only when every output bit holds NULL. It stays 0 for as long as any bit still holds DATA.
- R7: With `RST_DATA`=0, reset clears every rail, so the outputs are all 00 and `ko` is 1.
- R8: With `RST_DATA`=1, reset loads the word `RST_VAL` as DATA (bit i gives 01 if `RST_VAL[i]` is 1, else 10), and `ko` is 0.
- R9: The tree has ceil(log4 N) levels. A leftover single input in a level passes through without a gate. `ko` settles no later than depth+1 clock edges after the last bit's input meets `ki`.
- R10: While wavefronts alternate DATA and NULL under the handshake, no output bit ever shows the illegal code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that steps the hysteresis-gate model |
| rst_n | input | 1 | Asynchronous reset, active low |
| ki | input | 1 | Request from the downstream stage: 1 asks for DATA, 0 asks for NULL |
| din_r1 | input | N | Rail-1 of each incoming bit |
| din_r0 | input | N | Rail-0 of each incoming bit |
| dout_r1 | output | N | Rail-1 of each held bit |
| dout_r0 | output | N | Rail-0 of each held bit |
| ko | output | 1 | Full-word acknowledge to the upstream stage |

## Verification
The bench sweeps every 5-bit word and offers each one while the request still asks for null. A stage that ignored `ki` would latch it early. It then holds back one bit, which moves through every bit position, to catch a tree that drops its acknowledge before the word is whole. The five-bit width leaves one input to pass straight through a level, so a tree with a wrong depth or a misplaced pass-through shows up as a late or early `ko`. It also offers NULL under a data request and keeps one bit in DATA during the return to null: a register without hysteresis would clear too soon or raise `ko` while DATA is still present. A second instance reset to a DATA word checks the per-rail reset choice and its way back to NULL.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Number of signals left after `lvl` merge levels of up to four inputs each
  function automatic int unsigned tree_width(int unsigned n, int unsigned lvl);
    int unsigned w;
    w = n;
    for (int unsigned i = 0; i < lvl; i++) w = (w + 3) / 4;
    return w;
  endfunction

  // Levels needed to merge n acknowledges down to one (ceil(log4 n))
  function automatic int unsigned tree_depth(int unsigned n);
    int unsigned w;
    int unsigned d;
    w = n;
    d = 0;
    while (w > 1) begin
      w = (w + 3) / 4;
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/dr_hyst_gate.sv
module dr_hyst_gate #(
  parameter int unsigned W   = 2,
  parameter bit          RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in,
  output logic         out
);
  // All-of-W threshold with hysteresis: set when every input is high,
  // clear when every input is low, hold otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out <= RST;
    else if (&in)      out <= 1'b1;
    else if (!(|in))   out <= 1'b0;
  end

  a_r9_hold_on_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in) && !(&in)) |=> $stable(out));
endmodule

// File: rtl/dr_rail_cell.sv
module dr_rail_cell #(
  parameter bit RST_DATA = 1'b0,
  parameter bit RST_BIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ki,
  input  logic in_r1,
  input  logic in_r0,
  output logic q_r1,
  output logic q_r0,
  output logic ack
);
  localparam bit RST_R1 = RST_DATA &  RST_BIT;
  localparam bit RST_R0 = RST_DATA & !RST_BIT;

  dr_hyst_gate #(.W(2), .RST(RST_R1)) u_r1 (
    .clk(clk), .rst_n(rst_n), .in({in_r1, ki}), .out(q_r1));

  dr_hyst_gate #(.W(2), .RST(RST_R0)) u_r0 (
    .clk(clk), .rst_n(rst_n), .in({in_r0, ki}), .out(q_r0));

  // High while the bit holds NULL (asks for data), low while it holds DATA
  assign ack = ~(q_r1 | q_r0);
endmodule

// File: rtl/dr_cmpl_tree.sv
module dr_cmpl_tree #(
  parameter int unsigned N   = 8,
  parameter bit          RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ack,
  output logic         ko
);
  localparam int unsigned DEPTH = dr_pkg::tree_depth(N);

  generate
    if (DEPTH == 0) begin : g_flat
      assign ko = ack[0];
    end else begin : g_tree
      for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
        localparam int unsigned IW = dr_pkg::tree_width(N, l);
        localparam int unsigned OW = dr_pkg::tree_width(N, l + 1);
        logic [IW-1:0] lin;
        logic [OW-1:0] lout;

        if (l == 0) begin : g_src
          assign lin = ack;
        end else begin : g_src
          assign lin = g_lvl[l-1].lout;
        end

        for (genvar g = 0; g < OW; g++) begin : g_grp
          localparam int unsigned BASE = 4 * g;
          localparam int unsigned SZ   = (IW - BASE > 4) ? 4 : (IW - BASE);
          if (SZ == 1) begin : g_pass
            assign lout[g] = lin[BASE];
          end else begin : g_gate
            dr_hyst_gate #(.W(SZ), .RST(RST)) u_gate (
              .clk(clk), .rst_n(rst_n), .in(lin[BASE +: SZ]), .out(lout[g]));
          end
        end
      end
      assign ko = g_lvl[DEPTH-1].lout[0];
    end
  endgenerate
endmodule

// File: rtl/dr_reg_stage.sv
module dr_reg_stage #(
  parameter int unsigned N        = 8,
  parameter bit          RST_DATA = 1'b0,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ki,
  input  logic [N-1:0] din_r1,
  input  logic [N-1:0] din_r0,
  output logic [N-1:0] dout_r1,
  output logic [N-1:0] dout_r0,
  output logic         ko
);
  logic [N-1:0] bit_ack;
  logic [N-1:0] held;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      dr_rail_cell #(.RST_DATA(RST_DATA), .RST_BIT(RST_VAL[i])) u_cell (
        .clk(clk), .rst_n(rst_n), .ki(ki),
        .in_r1(din_r1[i]), .in_r0(din_r0[i]),
        .q_r1(dout_r1[i]), .q_r0(dout_r0[i]),
        .ack(bit_ack[i]));
    end
  endgenerate

  dr_cmpl_tree #(.N(N), .RST(!RST_DATA)) u_tree (
    .clk(clk), .rst_n(rst_n), .ack(bit_ack), .ko(ko));

  assign held = dout_r1 | dout_r0;

  // R2: a bit leaves NULL only under a data request
  a_r2_data_on_rfd: assert property (@(posedge clk) disable iff (!rst_n)
    (|(held & ~$past(held))) |-> $past(ki));

  // R3: a bit returns to NULL only under a null request
  a_r3_null_on_rfn: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~held & $past(held))) |-> !$past(ki));

  // R5: the word acknowledge drops only once the whole word is DATA
  a_r5_ko_fall_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ko) |-> (&held));

  // R6: the word acknowledge rises only once the whole word is NULL
  a_r6_ko_rise_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ko) |-> !(|held));
endmodule

// File: tb/dr_reg_stage_bench.sv
module dr_reg_stage_bench;
  localparam int unsigned NB = 5;
  localparam logic [NB-1:0] RVAL = 5'b10110;
  localparam logic [NB-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ki = 1'b1;
  logic [NB-1:0] din_r1 = '0, din_r0 = '0;
  logic [NB-1:0] dout_r1, dout_r0;
  logic          ko;

  logic          ki_b = 1'b1;
  logic [NB-1:0] dinb_r1 = '0, dinb_r0 = '0;
  logic [NB-1:0] doutb_r1, doutb_r0;
  logic          ko_b;

  int compared = 0;
  int mismatched = 0;
  int illegal_seen = 0;
  bit done = 1'b0;

  dr_reg_stage #(.N(NB), .RST_DATA(1'b0), .RST_VAL('0)) u_dr_reg_stage (
    .clk(clk), .rst_n(rst_n), .ki(ki), .din_r1(din_r1), .din_r0(din_r0),
    .dout_r1(dout_r1), .dout_r0(dout_r0), .ko(ko));

  dr_reg_stage #(.N(NB), .RST_DATA(1'b1), .RST_VAL(RVAL)) u_dr_reg_stage_rd (
    .clk(clk), .rst_n(rst_n), .ki(ki_b), .din_r1(dinb_r1), .din_r0(dinb_r0),
    .dout_r1(doutb_r1), .dout_r0(doutb_r0), .ko(ko_b));

  function automatic int bench_depth(int n);
    int w = n;
    int d = 0;
    while (w > 1) begin
      w = (w + 3) / 4;
      d++;
    end
    return d;
  endfunction

  localparam int DEP = bench_depth(NB);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R10: monitor for the illegal 11 code on any output bit
  always @(negedge clk) begin
    if (rst_n && (|(dout_r1 & dout_r0) || |(doutb_r1 & doutb_r0))) illegal_seen++;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R7 / R8: reset states
    chk("R7", "reset r1", dout_r1, 0);
    chk("R7", "reset r0", dout_r0, 0);
    chk("R7", "reset ko", ko, 1);
    chk("R8", "rdata r1", doutb_r1, RVAL);
    chk("R8", "rdata r0", doutb_r0, ~RVAL & MASK);
    chk("R8", "rdata ko", ko_b, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R7", "post-reset ko", ko, 1);
    chk("R3", "rdata held under rfd", doutb_r1, RVAL);

    // R8 instance back to NULL
    ki_b = 1'b0;
    cyc(DEP + 1);
    chk("R8", "rdata to null", doutb_r1 | doutb_r0, 0);
    chk("R6", "rdata ko rises", ko_b, 1);

    for (int v = 0; v < 32; v++) begin
      logic [NB-1:0] w1, w0, m;
      int k;
      w1 = v[NB-1:0];
      w0 = ~w1 & MASK;
      k = v % NB;
      m = ~(NB'(1) << k) & MASK;

      // R2: DATA offered under a null request is not taken
      ki = 1'b0;
      din_r1 = w1; din_r0 = w0;
      cyc(3);
      chk("R2", "data under rfn", dout_r1 | dout_r0, 0);
      chk("R2", "ko under rfn", ko, 1);

      // R5: one bit still NULL keeps ko high
      ki = 1'b1;
      din_r1 = w1 & m; din_r0 = w0 & m;
      cyc(DEP + 3);
      chk("R5", "partial ko", ko, 1);
      chk("R1", "partial r1", dout_r1, w1 & m);
      chk("R1", "partial r0", dout_r0, w0 & m);

      // R1, R4, R9: whole word completes, ko falls within depth+1 edges
      din_r1 = w1; din_r0 = w0;
      cyc(DEP + 1);
      chk("R1", "data r1", dout_r1, w1);
      chk("R1", "data r0", dout_r0, w0);
      chk("R9", "ko fell in time", ko, 0);

      // R3: NULL under a data request is not taken
      din_r1 = '0; din_r0 = '0;
      cyc(3);
      chk("R3", "null under rfd", dout_r1, w1);
      chk("R4", "ko stays low", ko, 0);

      // R6: one bit still DATA keeps ko low
      ki = 1'b0;
      din_r1 = w1 & ~m; din_r0 = w0 & ~m;
      cyc(DEP + 3);
      chk("R6", "partial null ko", ko, 0);
      chk("R6", "partial null out", dout_r1 | dout_r0, ~m & MASK);

      // R6, R9: full NULL, ko rises within depth+1 edges
      din_r1 = '0; din_r0 = '0;
      cyc(DEP + 1);
      chk("R4", "null out", dout_r1 | dout_r0, 0);
      chk("R9", "ko rose in time", ko, 1);
      ki = 1'b1;
      cyc(1);
    end

    chk("R10", "illegal codes seen", illegal_seen, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule